// File: doc/BRIEF.md
# Zero-turnaround synchronous SRAM model

This block is a synthesizable model of a synchronous static RAM. Its read and write cycles can follow each other in any mix with no idle cycle on the data bus. The block samples the address, the controls and the byte enables on each rising clock edge. A write's data follows its address on a later edge. In flow-through mode the data comes one edge later, and in pipelined mode two edges later. The write delay therefore matches the read latency of each mode, so a read followed by a write never contends for the bus.

Two static inputs set the behaviour. One selects the read path: pipelined, with an output register, or flow-through, with none. The other selects the 4-beat burst order: linear or interleaved. The block has three chip selects for depth expansion. Byte enables work on 9-bit bytes. An asynchronous output enable and an asynchronous sleep input can take the data outputs off the bus at any moment. In pipelined mode a read can reach a location whose delayed write has not yet landed in the array. The read then returns the pending bytes merged with the stored ones.

Top module: `zt_sram`

## Requirements
- R1: A new cycle starts only when `ce1_n` is low, `ce2` is high, `ce3_n` is low, `sleep` is low and `adv` is low. With any other combination and no burst continuing, the edge is a deselect: no access takes place, `dq_oe` stays low where that access's data would appear, and any running burst ends.
- R2: With `flow_mode`=1, a read's data and `dq_oe`=1 appear in the cycle right after the edge that sampled its address. They hold until the next edge.
- R3: With `flow_mode`=0, a read's data and `dq_oe`=1 appear one cycle later than in R2, in the second cycle after the address edge.
- R4: A write's data is taken from `din` on the first edge after its address edge when `flow_mode`=1, and on the second edge when `flow_mode`=0. The byte enables are taken on the address edge. A write never drives `dq_oe`.
- R5: A write stores `din[9i+8:9i]` when `bw_n[i]` is low. It leaves that byte of the word unchanged when `bw_n[i]` is high.
- R6: `adv` high during an active burst continues it in the same direction, ignoring the chip selects and `rw_n`. The upper address bits stay fixed. With `intlv`=0, beat k (k = 0..3) uses low bits (start + k) mod 4.
- R7: With `intlv`=1, beat k uses low bits start XOR k.
- R8: In pipelined mode, a read issued right behind a write can hit a delayed write that lands on the edge where the output register loads. Such a read returns that write's enabled bytes merged with the stored bytes, with no dead cycle in between.
- R9: `oe_n` high forces `dq_oe` low at once, without a clock edge. Lowering it again restores the pending read data.
- R10: `sleep` high forces `dq_oe` low at once. A command presented while `sleep` is high is ignored, and a write presented that way leaves the array unchanged.
- R11: After reset, `dq_oe` is low. `adv` high with no active burst is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flow_mode | input | 1 | Static: 1 selects flow-through, 0 selects pipelined |
| intlv | input | 1 | Static burst order: 0 linear, 1 interleaved |
| ce1_n | input | 1 | Chip select, active low |
| ce2 | input | 1 | Chip select, active high |
| ce3_n | input | 1 | Chip select, active low |
| sleep | input | 1 | Asynchronous power-down request |
| adv | input | 1 | Continue the current burst |
| rw_n | input | 1 | 1 read, 0 write (new cycles only) |
| addr | input | ADDR_W | Word address |
| bw_n | input | NBYTE | Per-byte write enables, active low |
| din | input | 9*NBYTE | Delayed write data |
| oe_n | input | 1 | Asynchronous output enable, active low |
| dq_out | output | 9*NBYTE | Read data |
| dq_oe | output | 1 | High when `dq_out` should drive the bus |

## Verification
The bench builds the block with `ADDR_W`=6 and `NBYTE`=2, which gives a 64-word, two-byte array. At that size every location the bench reads can first be written by the bench itself. Two bytes are enough to show one byte written while the other is held, both in the array and on the forwarding path. Because `flow_mode` and `intlv` are ports rather than parameters, this single build reaches both read latencies, both write delays and both burst orders, including a burst start address that is not aligned to four words.

// File: rtl/zt_pkg.sv
package zt_pkg;
  localparam int unsigned BEAT_BITS = 2;
  localparam int unsigned BYTE_W    = 9;

  typedef enum logic {
    ORD_LINEAR = 1'b0,
    ORD_INTLV  = 1'b1
  } burst_ord_e;

  // Low address bits for a given beat of a burst
  function automatic logic [BEAT_BITS-1:0] beat_lo(
    input logic [BEAT_BITS-1:0] start,
    input logic [BEAT_BITS-1:0] beat,
    input burst_ord_e           ord
  );
    if (ord == ORD_INTLV) return start ^ beat;
    return start + beat;
  endfunction
endpackage

// File: rtl/zt_burst_ctl.sv
module zt_burst_ctl
  import zt_pkg::*;
#(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned NBYTE  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sleep,
  input  logic              ce1_n,
  input  logic              ce2,
  input  logic              ce3_n,
  input  logic              adv,
  input  logic              rw_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [NBYTE-1:0]  bw_n,
  input  burst_ord_e        ord,
  output logic              op_vld,
  output logic              op_wr,
  output logic [ADDR_W-1:0] op_addr,
  output logic [NBYTE-1:0]  op_bw_n
);
  logic                 act_q, act_d;
  logic                 wr_q, wr_d;
  logic [ADDR_W-1:0]    base_q, base_d;
  logic [BEAT_BITS-1:0] beat_q, beat_d, beat_nx;
  logic                 chip_sel, new_cmd, cont, st_en;

  always_comb begin
    chip_sel = !ce1_n && ce2 && !ce3_n;
    new_cmd  = !sleep && !adv && chip_sel;
    cont     = !sleep && adv && act_q;
    beat_nx  = beat_q + 1'b1;
    st_en    = new_cmd || cont || act_q;
    act_d    = act_q;
    wr_d     = wr_q;
    base_d   = base_q;
    beat_d   = beat_q;
    if (new_cmd) begin
      act_d  = 1'b1;
      wr_d   = !rw_n;
      base_d = addr;
      beat_d = '0;
    end else if (cont) begin
      beat_d = beat_nx;
    end else begin
      act_d  = 1'b0;
    end
  end

  always_comb begin
    op_vld  = new_cmd || cont;
    op_wr   = new_cmd ? !rw_n : wr_q;
    op_addr = new_cmd ? addr
                      : {base_q[ADDR_W-1:BEAT_BITS], beat_lo(base_q[BEAT_BITS-1:0], beat_nx, ord)};
    op_bw_n = bw_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      wr_q   <= 1'b0;
      base_q <= '0;
      beat_q <= '0;
    end else if (st_en) begin
      act_q  <= act_d;
      wr_q   <= wr_d;
      base_q <= base_d;
      beat_q <= beat_d;
    end
  end

  AST_ADV_IDLE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !act_q) |-> !op_vld); // R11

  AST_BURST_PAGE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (op_vld && adv && $past(op_vld)) |->
      op_addr[ADDR_W-1:BEAT_BITS] == $past(op_addr[ADDR_W-1:BEAT_BITS])); // R6
endmodule

// File: rtl/zt_late_write.sv
module zt_late_write #(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned NBYTE  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flow_mode,
  input  logic              wr_issue,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [NBYTE-1:0]  wr_bw_n,
  output logic              commit_vld,
  output logic [ADDR_W-1:0] commit_addr,
  output logic [NBYTE-1:0]  commit_bw_n
);
  localparam int unsigned LAT_MAX = 2;

  for (genvar i = 0; i < LAT_MAX; i++) begin : g_stage
    logic              in_vld, vld_q;
    logic [ADDR_W-1:0] in_addr, addr_q;
    logic [NBYTE-1:0]  in_bw, bw_q;

    if (i == 0) begin : g_src
      assign in_vld  = wr_issue;
      assign in_addr = wr_addr;
      assign in_bw   = wr_bw_n;
    end else begin : g_src
      assign in_vld  = g_stage[i-1].vld_q;
      assign in_addr = g_stage[i-1].addr_q;
      assign in_bw   = g_stage[i-1].bw_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) vld_q <= 1'b0;
      else        vld_q <= in_vld;
    end

    always_ff @(posedge clk) begin
      if (in_vld) begin
        addr_q <= in_addr;
        bw_q   <= in_bw;
      end
    end
  end

  always_comb begin
    if (flow_mode) begin
      commit_vld  = g_stage[0].vld_q;
      commit_addr = g_stage[0].addr_q;
      commit_bw_n = g_stage[0].bw_q;
    end else begin
      commit_vld  = g_stage[LAT_MAX-1].vld_q;
      commit_addr = g_stage[LAT_MAX-1].addr_q;
      commit_bw_n = g_stage[LAT_MAX-1].bw_q;
    end
  end

  AST_FLOW_WRITE_ONE_LATE: assert property (@(posedge clk) disable iff (!rst_n)
    (flow_mode && wr_issue) |=> (commit_vld && commit_addr == $past(wr_addr))); // R4

  AST_PIPE_WRITE_TWO_LATE: assert property (@(posedge clk) disable iff (!rst_n)
    (!flow_mode && wr_issue) |=> ##1 (commit_vld && commit_addr == $past(wr_addr, 2))); // R4
endmodule

// File: rtl/zt_array_rd.sv
module zt_array_rd
  import zt_pkg::*;
#(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned NBYTE  = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    flow_mode,
  input  logic                    oe_n,
  input  logic                    sleep,
  input  logic                    rd_issue,
  input  logic [ADDR_W-1:0]       rd_addr,
  input  logic                    commit_vld,
  input  logic [ADDR_W-1:0]       commit_addr,
  input  logic [NBYTE-1:0]        commit_bw_n,
  input  logic [NBYTE*BYTE_W-1:0] din,
  output logic [NBYTE*BYTE_W-1:0] dq_out,
  output logic                    dq_oe
);
  localparam int unsigned WORD_W = NBYTE * BYTE_W;
  localparam int unsigned DEPTH  = 1 << ADDR_W;

  logic [WORD_W-1:0] mem [DEPTH];
  logic [WORD_W-1:0] at_commit, at_rd, commit_word, fwd_word, out_q;
  logic [ADDR_W-1:0] rd_addr_q;
  logic              rd_vld_q, out_vld_q, fwd_hit, data_vld;

  assign at_commit = mem[commit_addr];
  assign at_rd     = mem[rd_addr_q];
  assign fwd_hit   = commit_vld && (commit_addr == rd_addr_q);

  for (genvar g = 0; g < NBYTE; g++) begin : g_byte
    assign commit_word[g*BYTE_W +: BYTE_W] =
      commit_bw_n[g] ? at_commit[g*BYTE_W +: BYTE_W] : din[g*BYTE_W +: BYTE_W];
    assign fwd_word[g*BYTE_W +: BYTE_W] =
      (fwd_hit && !commit_bw_n[g]) ? din[g*BYTE_W +: BYTE_W] : at_rd[g*BYTE_W +: BYTE_W];
  end

  always_ff @(posedge clk) begin
    if (commit_vld) mem[commit_addr] <= commit_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_vld_q  <= 1'b0;
      out_vld_q <= 1'b0;
    end else begin
      rd_vld_q  <= rd_issue;
      out_vld_q <= rd_vld_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rd_issue) rd_addr_q <= rd_addr;
    if (rd_vld_q) out_q     <= fwd_word;
  end

  always_comb begin
    dq_out   = flow_mode ? at_rd : out_q;
    data_vld = flow_mode ? rd_vld_q : out_vld_q;
    dq_oe    = data_vld && !oe_n && !sleep;
  end

  AST_FLOW_NO_HAZARD: assert property (@(posedge clk) disable iff (!rst_n)
    (flow_mode && rd_vld_q) |-> !(commit_vld && commit_addr == rd_addr_q)); // R2

  AST_SLEEP_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |=> !rd_vld_q); // R10
endmodule

// File: rtl/zt_sram.sv
module zt_sram
  import zt_pkg::*;
#(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned NBYTE  = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    flow_mode,
  input  logic                    intlv,
  input  logic                    ce1_n,
  input  logic                    ce2,
  input  logic                    ce3_n,
  input  logic                    sleep,
  input  logic                    adv,
  input  logic                    rw_n,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [NBYTE-1:0]        bw_n,
  input  logic [NBYTE*BYTE_W-1:0] din,
  input  logic                    oe_n,
  output logic [NBYTE*BYTE_W-1:0] dq_out,
  output logic                    dq_oe
);
  logic              op_vld, op_wr;
  logic [ADDR_W-1:0] op_addr, commit_addr;
  logic [NBYTE-1:0]  op_bw_n, commit_bw_n;
  logic              commit_vld;
  burst_ord_e        ord;

  assign ord = burst_ord_e'(intlv);

  zt_burst_ctl #(.ADDR_W(ADDR_W), .NBYTE(NBYTE)) u_ctl (
    .clk(clk), .rst_n(rst_n), .sleep(sleep),
    .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n),
    .adv(adv), .rw_n(rw_n), .addr(addr), .bw_n(bw_n), .ord(ord),
    .op_vld(op_vld), .op_wr(op_wr), .op_addr(op_addr), .op_bw_n(op_bw_n)
  );

  zt_late_write #(.ADDR_W(ADDR_W), .NBYTE(NBYTE)) u_lw (
    .clk(clk), .rst_n(rst_n), .flow_mode(flow_mode),
    .wr_issue(op_vld && op_wr), .wr_addr(op_addr), .wr_bw_n(op_bw_n),
    .commit_vld(commit_vld), .commit_addr(commit_addr), .commit_bw_n(commit_bw_n)
  );

  zt_array_rd #(.ADDR_W(ADDR_W), .NBYTE(NBYTE)) u_arr (
    .clk(clk), .rst_n(rst_n), .flow_mode(flow_mode), .oe_n(oe_n), .sleep(sleep),
    .rd_issue(op_vld && !op_wr), .rd_addr(op_addr),
    .commit_vld(commit_vld), .commit_addr(commit_addr), .commit_bw_n(commit_bw_n),
    .din(din), .dq_out(dq_out), .dq_oe(dq_oe)
  );
endmodule

// File: tb/sim_zt_sram.sv
module sim_zt_sram;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 6;
  localparam int NB = 2;
  localparam int DW = NB * 9;

  typedef struct packed {
    logic [3:0]    req;
    logic [4:0]    fl_il_sel_rd_adv;
    logic [AW-1:0] addr;
    logic [NB-1:0] bw;
    logic [DW-1:0] din;
    logic          eoe;
    logic [DW-1:0] edq;
  } vec_t;

  localparam int NV = 33;
  // Expectations of a row reflect edges before that row's inputs are applied.
  localparam vec_t VEC [NV] = '{
    {4'd11, 5'b00100, 6'h10, 2'b00, 18'h00000, 1'b0, 18'h00000}, // reset state, write 10
    {4'd4,  5'b00100, 6'h11, 2'b00, 18'h00000, 1'b0, 18'h00000}, // write 11
    {4'd4,  5'b00110, 6'h10, 2'b00, 18'h11111, 1'b0, 18'h00000}, // R4 data for 10
    {4'd4,  5'b00110, 6'h11, 2'b00, 18'h22222, 1'b0, 18'h00000}, // data for 11
    {4'd3,  5'b00100, 6'h12, 2'b00, 18'h00000, 1'b1, 18'h11111}, // R3 read 10
    {4'd3,  5'b00110, 6'h12, 2'b00, 18'h00000, 1'b1, 18'h22222}, // read 12 behind write
    {4'd4,  5'b00100, 6'h10, 2'b10, 18'h33333, 1'b0, 18'h00000}, // data 12, write 10 byte0
    {4'd8,  5'b00110, 6'h10, 2'b00, 18'h00000, 1'b1, 18'h33333}, // R8 forwarded
    {4'd5,  5'b00000, 6'h00, 2'b00, 18'h3FE00, 1'b0, 18'h00000}, // byte data for 10
    {4'd5,  5'b00000, 6'h00, 2'b00, 18'h00000, 1'b1, 18'h11000}, // R5 merged forward
    {4'd1,  5'b00100, 6'h21, 2'b00, 18'h00000, 1'b0, 18'h00000}, // linear write burst
    {4'd6,  5'b00011, 6'h3F, 2'b00, 18'h00000, 1'b0, 18'h00000}, // R6 adv, ce and rw ignored
    {4'd6,  5'b00011, 6'h3F, 2'b00, 18'h0A001, 1'b0, 18'h00000},
    {4'd6,  5'b00011, 6'h3F, 2'b00, 18'h0A002, 1'b0, 18'h00000},
    {4'd6,  5'b00110, 6'h20, 2'b00, 18'h0A003, 1'b0, 18'h00000}, // read burst at 20
    {4'd6,  5'b00011, 6'h3F, 2'b00, 18'h0A004, 1'b0, 18'h00000},
    {4'd8,  5'b00011, 6'h3F, 2'b00, 18'h00000, 1'b1, 18'h0A004},
    {4'd6,  5'b00011, 6'h3F, 2'b00, 18'h00000, 1'b1, 18'h0A001},
    {4'd6,  5'b00000, 6'h00, 2'b00, 18'h00000, 1'b1, 18'h0A002},
    {4'd6,  5'b00000, 6'h00, 2'b00, 18'h00000, 1'b1, 18'h0A003},
    {4'd1,  5'b00000, 6'h00, 2'b00, 18'h00000, 1'b0, 18'h00000}, // deselect, no data
    {4'd7,  5'b11100, 6'h32, 2'b00, 18'h00000, 1'b0, 18'h00000}, // R7 flow write burst
    {4'd4,  5'b11001, 6'h00, 2'b00, 18'h0B000, 1'b0, 18'h00000},
    {4'd4,  5'b11001, 6'h00, 2'b00, 18'h0B001, 1'b0, 18'h00000},
    {4'd4,  5'b11001, 6'h00, 2'b00, 18'h0B002, 1'b0, 18'h00000},
    {4'd4,  5'b11110, 6'h33, 2'b00, 18'h0B003, 1'b0, 18'h00000}, // read burst at 33
    {4'd2,  5'b11011, 6'h00, 2'b00, 18'h00000, 1'b1, 18'h0B001}, // R2 one cycle
    {4'd7,  5'b11011, 6'h00, 2'b00, 18'h00000, 1'b1, 18'h0B000},
    {4'd7,  5'b11011, 6'h00, 2'b00, 18'h00000, 1'b1, 18'h0B003},
    {4'd7,  5'b11100, 6'h30, 2'b01, 18'h00000, 1'b1, 18'h0B002}, // write 30 byte1
    {4'd4,  5'b11110, 6'h30, 2'b00, 18'h3FFFF, 1'b0, 18'h00000},
    {4'd5,  5'b11000, 6'h00, 2'b00, 18'h00000, 1'b1, 18'h3FE02},
    {4'd2,  5'b11000, 6'h00, 2'b00, 18'h00000, 1'b0, 18'h00000}
  };

  logic          clk, rst_n, flow_mode, intlv, ce1_n, ce2, ce3_n;
  logic          sleep, adv, rw_n, oe_n, dq_oe;
  logic [AW-1:0] addr;
  logic [NB-1:0] bw_n;
  logic [DW-1:0] din, dq_out;
  int            errs, total;

  zt_sram #(.ADDR_W(AW), .NBYTE(NB)) u0 (
    .clk(clk), .rst_n(rst_n), .flow_mode(flow_mode), .intlv(intlv),
    .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n), .sleep(sleep), .adv(adv),
    .rw_n(rw_n), .addr(addr), .bw_n(bw_n), .din(din), .oe_n(oe_n),
    .dq_out(dq_out), .dq_oe(dq_oe)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string tag, input logic [DW:0] act, input logic [DW:0] exp);
    total++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual oe/data=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_oe(input logic exp_oe, input logic [DW-1:0] exp_dq, input string tag);
    if (exp_oe) check(dq_oe === 1'b1 && dq_out === exp_dq, tag, {dq_oe, dq_out}, {1'b1, exp_dq});
    else        check(dq_oe === 1'b0, tag, {dq_oe, {DW{1'b0}}}, {1'b0, {DW{1'b0}}});
  endtask

  task automatic step(input logic [2:0] ce_ok, input logic rd, input logic ad,
                      input logic [AW-1:0] a, input logic [NB-1:0] bw, input logic [DW-1:0] d);
    @(negedge clk);
    ce1_n = !ce_ok[0]; ce2 = ce_ok[1]; ce3_n = !ce_ok[2];
    rw_n = rd; adv = ad; addr = a; bw_n = bw; din = d;
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    errs++; total++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errs, total);
    $finish;
  end

  initial begin
    errs = 0; total = 0;
    rst_n = 1'b0; flow_mode = 1'b0; intlv = 1'b0; sleep = 1'b0; oe_n = 1'b0;
    ce1_n = 1'b1; ce2 = 1'b0; ce3_n = 1'b1; adv = 1'b0; rw_n = 1'b1;
    addr = '0; bw_n = '1; din = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      check_oe(VEC[i].eoe, VEC[i].edq, $sformatf("R%0d row %0d", VEC[i].req, i));
      flow_mode = VEC[i].fl_il_sel_rd_adv[4];
      intlv     = VEC[i].fl_il_sel_rd_adv[3];
      ce1_n     = !VEC[i].fl_il_sel_rd_adv[2];
      ce2       = VEC[i].fl_il_sel_rd_adv[2];
      ce3_n     = !VEC[i].fl_il_sel_rd_adv[2];
      rw_n      = VEC[i].fl_il_sel_rd_adv[1];
      adv       = VEC[i].fl_il_sel_rd_adv[0];
      addr      = VEC[i].addr;
      bw_n      = VEC[i].bw;
      din       = VEC[i].din;
    end

    // R9: output enable acts without a clock edge (flow mode, word 30 = 3FE02)
    step(3'b111, 1'b1, 1'b0, 6'h30, 2'b00, '0);
    step(3'b000, 1'b1, 1'b0, 6'h00, 2'b00, '0);
    check_oe(1'b1, 18'h3FE02, "R9 read before oe");
    oe_n = 1'b1; #1;
    check_oe(1'b0, '0, "R9 oe_n high");
    oe_n = 1'b0; #1;
    check_oe(1'b1, 18'h3FE02, "R9 oe_n low again");

    // R10: sleep blanks the bus at once and blocks a write
    sleep = 1'b1; #1;
    check_oe(1'b0, '0, "R10 sleep blanks");
    step(3'b111, 1'b0, 1'b0, 6'h30, 2'b00, '0);
    step(3'b000, 1'b1, 1'b0, 6'h00, 2'b00, 18'h15555);
    step(3'b000, 1'b1, 1'b0, 6'h00, 2'b00, 18'h15555);
    sleep = 1'b0;
    step(3'b111, 1'b1, 1'b0, 6'h30, 2'b00, '0);
    step(3'b000, 1'b1, 1'b0, 6'h00, 2'b00, '0);
    check_oe(1'b1, 18'h3FE02, "R10 write under sleep ignored");

    // R1: each chip select alone blocks the cycle
    for (int k = 0; k < 3; k++) begin
      step(3'b111 & ~(3'b001 << k), 1'b1, 1'b0, 6'h30, 2'b00, '0);
      step(3'b000, 1'b1, 1'b0, 6'h00, 2'b00, '0);
      check_oe(1'b0, '0, $sformatf("R1 select %0d off", k));
    end

    // R11: advance with no burst is ignored; reset clears the output
    step(3'b111, 1'b1, 1'b1, 6'h30, 2'b00, '0);
    step(3'b000, 1'b1, 1'b0, 6'h00, 2'b00, '0);
    check_oe(1'b0, '0, "R11 adv without burst");
    step(3'b111, 1'b1, 1'b0, 6'h30, 2'b00, '0);
    step(3'b000, 1'b1, 1'b0, 6'h00, 2'b00, '0);
    check_oe(1'b1, 18'h3FE02, "R11 read before reset");
    rst_n = 1'b0; #1;
    check_oe(1'b0, '0, "R11 reset clears oe");
    @(negedge clk);
    rst_n = 1'b1;

    $display("Result: errors=%0d of %0d checks", errs, total);
    $finish;
  end
endmodule